// File: doc/BRIEF.md
# Microcoded Dual-Bus Register Datapath

This block is a 16-bit datapath slice driven directly by decoded microword fields. Sixteen general registers feed two read ports. Each cycle the block builds an X-side address bus, a Y-side address bus and a local data bus. Every bus picks its source from the register ports, the right-hand buses, a microword constant, a byte-swapped copy of the X bus, or a readback of the ALU status flags. A small add/pass/subtract unit works on the two address buses and supplies the flags.

A 5-bit destination address is split in two halves. Its low half writes the general registers from the local data bus. The first four codes of its high half load four display-control registers, and these take their data from the right-hand data bus instead. A mux sends four condition lines to an external sequencer, and a 2-bit field picks the vector placed on them.

When an outside bus master takes the block, both address buses carry the halves of its half-word address, whatever the microword asks for.

Top module: `mc_dualbus_datapath`

## Requirements
- R1: `xbus` carries register port A when `xsel`=0 and carries `right_a` when `xsel`=1. Port A is addressed by `rd_addr_x`.
- R2: `ybus` follows `ysel`. Code 00 gives register port B, which is addressed by `dst_addr[3:0]`. Code 01 gives `right_b`, 10 gives `const_word`, and 11 gives all zeros.
- R3: `ldbus` follows `ldsel`. Code 00 gives the ALU result and 01 gives `right_data`. Code 10 gives `xbus` with its two bytes exchanged (`{xbus[7:0],xbus[15:8]}`). Code 11 gives zeros except bits 3:0, which hold {zero, carry, negative, overflow} with zero on bit 3.
- R4: The ALU operates on `xbus` (a) and `ybus` (b). For `alu_op` 00 the result is a+b, with carry = bit 16 of the sum. Code 01 passes a and code 10 passes b, with carry and overflow both 0. Code 11 gives a-b, computed as a + ~b + 1, with carry = bit 16 of that sum. Zero is set when the result is 0, and negative is result bit 15. Overflow is set for add and subtract when signed overflow occurs.
- R5: On a rising edge with `wr_en`=1 and `dst_addr[4]`=0, general register `dst_addr[3:0]` loads `ldbus`.
- R6: On a rising edge with `wr_en`=1, codes 10000, 10001, 10010 and 10011 load `disp_colour`, `disp_planes`, `disp_xoff` and `disp_yoff` in that order. They load from `right_data`, and no general register changes.
- R7: A write with `dst_addr` from 10100 to 11111 changes no display register and no general register.
- R8: `cond[3:0]` follows `condsel`. Code 00 gives {zero, negative, carry, overflow}. Code 01 gives {`dma_a_done`, ldbus[4], `dma_b_done`, ldbus[7]}. Code 10 gives {ldbus[0], ldbus[3], ldbus[2], ldbus[6]}. Code 11 gives {0, `vblank`, ldbus[1], ldbus[5]}. The first element of each vector sits on cond[3].
- R9: While `ext_req`=1, `xbus` = {0, `ext_addr[31:17]`} and `ybus` = `ext_addr[16:1]`, regardless of `xsel` and `ysel`.
- R10: An active-low `rst_n` clears all general and display registers to zero at once.
- R11: With `wr_en`=0, no register changes at the clock edge, whatever `dst_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| xsel | input | 1 | X bus source select |
| ysel | input | 2 | Y bus source select |
| ldsel | input | 2 | Local data bus source select |
| condsel | input | 2 | Condition vector select |
| alu_op | input | 2 | ALU operation |
| rd_addr_x | input | 4 | Read port A register address |
| dst_addr | input | 5 | Write address, also read port B address (low 4 bits) |
| wr_en | input | 1 | Write strobe for the addressed destination |
| const_word | input | 16 | Microword constant |
| right_a | input | 16 | Right-side A address bus |
| right_b | input | 16 | Right-side B address bus |
| right_data | input | 16 | Right-side data bus |
| ext_req | input | 1 | External bus master access active |
| ext_addr | input | 31 | External half-word address, bits 31:1 |
| dma_a_done | input | 1 | A-side DMA completion |
| dma_b_done | input | 1 | B-side DMA completion |
| vblank | input | 1 | Vertical blanking flag |
| xbus | output | 16 | X-side address bus |
| ybus | output | 16 | Y-side address bus |
| ldbus | output | 16 | Local data bus |
| cond | output | 4 | Condition lines to the sequencer |
| disp_colour | output | 16 | Colour display register |
| disp_planes | output | 16 | Plane write enable register |
| disp_xoff | output | 16 | X display offset register |
| disp_yoff | output | 16 | Y display offset register |

## Verification
The clocked assertions assume that the microword fields, the write strobe and the right-side buses are settled before the rising edge. The write-visibility checks also assume that a register read in the cycle after a write uses the address that was latched by that write. The bench changes every input only on the falling edge, so each field holds still across the edge that samples it. The external override is raised only in cycles with `wr_en` low, which keeps the override checks apart from register updates.

// File: rtl/dp_pkg.sv
package dp_pkg;
  parameter int DP_W    = 16;
  parameter int DP_REGS = 16;
  parameter int DP_DISP = 4;
  localparam int DP_RA_W = $clog2(DP_REGS);
  localparam int DP_WA_W = DP_RA_W + 1;
  localparam int DP_EXT_LO = 1;
  localparam int DP_EXT_HI = 2 * DP_W - 1;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_PSA = 2'b01,
    ALU_PSB = 2'b10,
    ALU_SUB = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic carry;
    logic negative;
    logic overflow;
  } flags_t;

  typedef struct packed {
    logic [DP_W-1:0] res;
    flags_t          fl;
  } alu_out_t;

  function automatic alu_out_t alu_eval(input logic [1:0] op,
                                        input logic [DP_W-1:0] a,
                                        input logic [DP_W-1:0] b);
    alu_out_t      o;
    logic [DP_W:0] wide;
    logic [DP_W-1:0] bb;
    o = '0;
    bb = (op == ALU_SUB) ? ~b : b;
    wide = {1'b0, a} + {1'b0, bb} + {{DP_W{1'b0}}, (op == ALU_SUB)};
    case (op)
      ALU_PSA: o.res = a;
      ALU_PSB: o.res = b;
      default: begin
        o.res = wide[DP_W-1:0];
        o.fl.carry = wide[DP_W];
        o.fl.overflow = (a[DP_W-1] == bb[DP_W-1]) && (o.res[DP_W-1] != a[DP_W-1]);
      end
    endcase
    o.fl.zero = (o.res == '0);
    o.fl.negative = o.res[DP_W-1];
    return o;
  endfunction

  function automatic logic [DP_W-1:0] byte_swap(input logic [DP_W-1:0] v);
    return {v[DP_W/2-1:0], v[DP_W-1:DP_W/2]};
  endfunction
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile
  import dp_pkg::*;
#(
  parameter int W = DP_W,
  parameter int N = DP_REGS,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [N-1:0][W-1:0] mem;
  logic [N-1:0]        row_we;

  for (genvar g = 0; g < N; g++) begin : g_row
    assign row_we[g] = we && (wa == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem[g] <= '0;
      else if (row_we[g]) mem[g] <= wd;
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];

  assert_one_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_we));
  assert_write_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ra_b != $past(wa)) || (rd_b == $past(wd)));
  assert_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
(
  input  logic [1:0]      op,
  input  logic [DP_W-1:0] a,
  input  logic [DP_W-1:0] b,
  output logic [DP_W-1:0] res,
  output flags_t          fl
);
  alu_out_t o;
  always_comb begin
    o   = alu_eval(op, a, b);
    res = o.res;
    fl  = o.fl;
  end
endmodule

// File: rtl/dp_display_regs.sv
module dp_display_regs
  import dp_pkg::*;
#(
  parameter int W  = DP_W,
  parameter int N  = DP_DISP,
  parameter int AW = DP_WA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [W-1:0]      wd,
  output logic [N-1:0][W-1:0] regs
);
  logic [N-1:0] hit;
  logic         upper_miss;

  for (genvar g = 0; g < N; g++) begin : g_disp
    assign hit[g] = we && addr[AW-1] && (addr[AW-2:0] == (AW-1)'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs[g] <= '0;
      else if (hit[g]) regs[g] <= wd;
    end
    assert_disp_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> regs[g] == $past(wd));
  end

  assign upper_miss = we && addr[AW-1] && (addr[AW-2:0] >= (AW-1)'(N));

  assert_disp_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  assert_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upper_miss |=> $stable(regs));
endmodule

// File: rtl/dp_route.sv
module dp_route
  import dp_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xsel,
  input  logic [1:0]                 ysel,
  input  logic [1:0]                 ldsel,
  input  logic [1:0]                 condsel,
  input  logic [DP_W-1:0]            port_a,
  input  logic [DP_W-1:0]            port_b,
  input  logic [DP_W-1:0]            right_a,
  input  logic [DP_W-1:0]            right_b,
  input  logic [DP_W-1:0]            right_data,
  input  logic [DP_W-1:0]            const_word,
  input  logic                       ext_req,
  input  logic [DP_EXT_HI:DP_EXT_LO] ext_addr,
  input  logic [DP_W-1:0]            alu_res,
  input  flags_t                     fl,
  input  logic                       dma_a_done,
  input  logic                       dma_b_done,
  input  logic                       vblank,
  output logic [DP_W-1:0]            xbus,
  output logic [DP_W-1:0]            ybus,
  output logic [DP_W-1:0]            ldbus,
  output logic [3:0]                 cond
);
  always_comb begin
    if (ext_req)   xbus = {1'b0, ext_addr[DP_EXT_HI:DP_W+1]};
    else if (xsel) xbus = right_a;
    else           xbus = port_a;
  end

  always_comb begin
    if (ext_req) ybus = ext_addr[DP_W:DP_EXT_LO];
    else begin
      case (ysel)
        2'b00:   ybus = port_b;
        2'b01:   ybus = right_b;
        2'b10:   ybus = const_word;
        default: ybus = '0;
      endcase
    end
  end

  always_comb begin
    case (ldsel)
      2'b00:   ldbus = alu_res;
      2'b01:   ldbus = right_data;
      2'b10:   ldbus = byte_swap(xbus);
      default: ldbus = {{(DP_W-4){1'b0}}, fl};
    endcase
  end

  always_comb begin
    case (condsel)
      2'b00:   cond = {fl.zero, fl.negative, fl.carry, fl.overflow};
      2'b01:   cond = {dma_a_done, ldbus[4], dma_b_done, ldbus[7]};
      2'b10:   cond = {ldbus[0], ldbus[3], ldbus[2], ldbus[6]};
      default: cond = {1'b0, vblank, ldbus[1], ldbus[5]};
    endcase
  end

  assert_ext_x_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (xbus[DP_W-1] == 1'b0) && (xbus[DP_W-2:0] == ext_addr[DP_EXT_HI:DP_W+1]));
  assert_ext_y_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> ybus == ext_addr[DP_W:DP_EXT_LO]);
  assert_cond_ground_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (condsel == 2'b11) |-> !cond[3]);
  assert_status_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ldsel == 2'b11) |-> (ldbus[DP_W-1:4] == '0) && (ldbus[3] == (alu_res == '0)));
endmodule

// File: rtl/mc_dualbus_datapath.sv
module mc_dualbus_datapath
  import dp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xsel,
  input  logic [1:0]        ysel,
  input  logic [1:0]        ldsel,
  input  logic [1:0]        condsel,
  input  logic [1:0]        alu_op,
  input  logic [3:0]        rd_addr_x,
  input  logic [4:0]        dst_addr,
  input  logic              wr_en,
  input  logic [15:0]       const_word,
  input  logic [15:0]       right_a,
  input  logic [15:0]       right_b,
  input  logic [15:0]       right_data,
  input  logic              ext_req,
  input  logic [31:1]       ext_addr,
  input  logic              dma_a_done,
  input  logic              dma_b_done,
  input  logic              vblank,
  output logic [15:0]       xbus,
  output logic [15:0]       ybus,
  output logic [15:0]       ldbus,
  output logic [3:0]        cond,
  output logic [15:0]       disp_colour,
  output logic [15:0]       disp_planes,
  output logic [15:0]       disp_xoff,
  output logic [15:0]       disp_yoff
);
  logic [DP_W-1:0]              port_a, port_b, alu_res;
  flags_t                       fl;
  logic                         gen_we;
  logic                         disp_we;
  logic [DP_DISP-1:0][DP_W-1:0] disp;

  assign gen_we  = wr_en && !dst_addr[DP_WA_W-1];
  assign disp_we = wr_en &&  dst_addr[DP_WA_W-1];

  dp_regfile i_regs (
    .clk(clk), .rst_n(rst_n), .we(gen_we), .wa(dst_addr[DP_RA_W-1:0]), .wd(ldbus),
    .ra_a(rd_addr_x), .ra_b(dst_addr[DP_RA_W-1:0]), .rd_a(port_a), .rd_b(port_b)
  );

  dp_alu i_alu (.op(alu_op), .a(xbus), .b(ybus), .res(alu_res), .fl(fl));

  dp_route i_route (
    .clk(clk), .rst_n(rst_n), .xsel(xsel), .ysel(ysel), .ldsel(ldsel), .condsel(condsel),
    .port_a(port_a), .port_b(port_b), .right_a(right_a), .right_b(right_b),
    .right_data(right_data), .const_word(const_word), .ext_req(ext_req),
    .ext_addr(ext_addr), .alu_res(alu_res), .fl(fl), .dma_a_done(dma_a_done),
    .dma_b_done(dma_b_done), .vblank(vblank), .xbus(xbus), .ybus(ybus),
    .ldbus(ldbus), .cond(cond)
  );

  dp_display_regs i_disp (
    .clk(clk), .rst_n(rst_n), .we(disp_we), .addr(dst_addr), .wd(right_data), .regs(disp)
  );

  assign disp_colour = disp[0];
  assign disp_planes = disp[1];
  assign disp_xoff   = disp[2];
  assign disp_yoff   = disp[3];

  assert_disp_no_gen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_we |-> !gen_we);
endmodule

// File: tb/test_mc_dualbus_datapath.sv
module test_mc_dualbus_datapath;
  logic clk = 0, rst_n = 0;
  logic xsel = 0; logic [1:0] ysel = 0, ldsel = 0, condsel = 0, alu_op = 0;
  logic [3:0] rd_addr_x = 0; logic [4:0] dst_addr = 0; logic wr_en = 0;
  logic [15:0] const_word = 0, right_a = 0, right_b = 0, right_data = 0;
  logic ext_req = 0; logic [31:1] ext_addr = 0;
  logic dma_a_done = 0, dma_b_done = 0, vblank = 0;
  logic [15:0] xbus, ybus, ldbus, disp_colour, disp_planes, disp_xoff, disp_yoff;
  logic [3:0] cond;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mc_dualbus_datapath i_mc_dualbus_datapath (.*);

  typedef struct packed {
    logic [1:0] yb; logic [1:0] ld; logic [1:0] op;
    logic [15:0] ra, rb, rd, k, ex, ey, eld;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'b01, 2'b00, 2'b00, 16'h1234, 16'h1111, 16'h0000, 16'h0000, 16'h1234, 16'h1111, 16'h2345},
    '{2'b10, 2'b00, 2'b00, 16'hFFFF, 16'h0000, 16'h0000, 16'h0001, 16'hFFFF, 16'h0001, 16'h0000},
    '{2'b10, 2'b11, 2'b00, 16'hFFFF, 16'h0000, 16'h0000, 16'h0001, 16'hFFFF, 16'h0001, 16'h000C},
    '{2'b10, 2'b11, 2'b00, 16'h7FFF, 16'h0000, 16'h0000, 16'h0001, 16'h7FFF, 16'h0001, 16'h0003},
    '{2'b11, 2'b10, 2'b00, 16'hABCD, 16'h9999, 16'h0000, 16'h7777, 16'hABCD, 16'h0000, 16'hCDAB},
    '{2'b01, 2'b01, 2'b00, 16'h0000, 16'h0000, 16'h5A5A, 16'h0000, 16'h0000, 16'h0000, 16'h5A5A},
    '{2'b10, 2'b11, 2'b11, 16'h0005, 16'h0000, 16'h0000, 16'h0007, 16'h0005, 16'h0007, 16'h0002},
    '{2'b10, 2'b00, 2'b10, 16'h0001, 16'h0000, 16'h0000, 16'h8000, 16'h0001, 16'h8000, 16'h8000},
    '{2'b01, 2'b11, 2'b01, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h0008},
    '{2'b11, 2'b00, 2'b01, 16'h00FF, 16'h0000, 16'h0000, 16'h0000, 16'h00FF, 16'h0000, 16'h00FF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'h1357 ^ 16'(i * 16'h0F11);
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state, read through both ports
    dst_addr = 5'd5; #2;
    chk("R10 xbus", xbus, 16'h0000);
    chk("R10 ybus", ybus, 16'h0000);
    chk("R10 colour", disp_colour, 16'h0000);
    chk("R10 yoff", disp_yoff, 16'h0000);

    // Table: R1 R2 R3 R4 through xsel=1 and non-register Y sources
    xsel = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ysel = VEC[i].yb; ldsel = VEC[i].ld; alu_op = VEC[i].op;
      right_a = VEC[i].ra; right_b = VEC[i].rb; right_data = VEC[i].rd; const_word = VEC[i].k;
      #2;
      chk("R1 xbus", xbus, VEC[i].ex);
      chk("R2 ybus", ybus, VEC[i].ey);
      chk("R3/R4 ldbus", ldbus, VEC[i].eld);
    end

    // R5: fill the general registers from right_data via ldbus
    @(negedge clk);
    ldsel = 2'b01; wr_en = 1;
    for (int i = 0; i < 16; i++) begin
      dst_addr = 5'(i); right_data = pat(i);
      step();
    end
    wr_en = 0; xsel = 0; ysel = 2'b00;
    for (int i = 0; i < 16; i++) begin
      rd_addr_x = 4'(i); dst_addr = 5'(15 - i); #2;
      chk("R5 port A", xbus, pat(i));
      chk("R5 port B", ybus, pat(15 - i));
      @(negedge clk);
    end

    // R5 with ALU result as source: r2 := r1 + r3
    rd_addr_x = 4'd1; dst_addr = 5'd3; ldsel = 2'b00; alu_op = 2'b00; #2;
    dst_addr = 5'd2; ysel = 2'b10; const_word = pat(3); wr_en = 1;
    step(); wr_en = 0; ysel = 2'b00; #2;
    chk("R5 alu write", ybus, 16'(pat(1) + pat(3)));

    // R11: write strobe low leaves register unchanged
    ldsel = 2'b01; right_data = 16'hDEAD; dst_addr = 5'd7; wr_en = 0;
    step(); #2;
    chk("R11 no write", ybus, pat(7));

    // R6: display registers load from right_data, not ldbus
    ldsel = 2'b10; xsel = 1; right_a = 16'h0F0F; wr_en = 1;
    for (int i = 0; i < 4; i++) begin
      dst_addr = 5'(16 + i); right_data = 16'hA000 + 16'(i);
      step();
    end
    wr_en = 0; #2;
    chk("R6 colour", disp_colour, 16'hA000);
    chk("R6 planes", disp_planes, 16'hA001);
    chk("R6 xoff", disp_xoff, 16'hA002);
    chk("R6 yoff", disp_yoff, 16'hA003);
    xsel = 0; ysel = 2'b00;
    for (int i = 0; i < 4; i++) begin
      dst_addr = 5'(i); #2;
      chk("R6 general untouched", ybus, (i == 2) ? 16'(pat(1) + pat(3)) : pat(i));
      @(negedge clk);
    end

    // R7: upper unused codes ignored
    wr_en = 1; ldsel = 2'b01; right_data = 16'hFFFF;
    for (int i = 20; i < 32; i++) begin
      dst_addr = 5'(i);
      step();
    end
    wr_en = 0; #2;
    chk("R7 colour", disp_colour, 16'hA000);
    chk("R7 planes", disp_planes, 16'hA001);
    chk("R7 xoff", disp_xoff, 16'hA002);
    chk("R7 yoff", disp_yoff, 16'hA003);
    for (int i = 4; i < 16; i++) begin
      dst_addr = 5'(i); #2;
      chk("R7 general untouched", ybus, pat(i));
      @(negedge clk);
    end

    // R8: condition vectors, ldbus = 0x00B5
    ldsel = 2'b01; right_data = 16'h00B5; dma_a_done = 1; dma_b_done = 0; vblank = 1;
    condsel = 2'b01; #2; chk("R8 sel01", 16'(cond), 16'hD);
    condsel = 2'b10; #2; chk("R8 sel10", 16'(cond), 16'hA);
    condsel = 2'b11; #2; chk("R8 sel11", 16'(cond), 16'h5);
    xsel = 1; right_a = 0; ysel = 2'b11; alu_op = 2'b00; condsel = 2'b00; #2;
    chk("R8 sel00 flags", 16'(cond), 16'h8);
    @(negedge clk);

    // R9: external master override
    ext_req = 1; ext_addr = 31'(32'hDEADBEEE >> 1); xsel = 0; ysel = 2'b10; ldsel = 2'b10; #2;
    chk("R9 xbus", xbus, 16'h6F56);
    chk("R9 ybus", ybus, 16'hDF77);
    chk("R9/R3 swap", ldbus, 16'h566F);
    @(negedge clk);
    ext_req = 0;

    // R10: asynchronous reset clears registers
    #3 rst_n = 0; #2;
    chk("R10 async colour", disp_colour, 16'h0000);
    dst_addr = 5'd9; xsel = 0; ysel = 2'b00; #1;
    chk("R10 async general", ybus, 16'h0000);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule